// File: doc/BRIEF.md
# I2C Slave Receiver with Host Status Codes

This block is the receive half of an I2C-bus slave, run by a host processor through four byte-wide registers. It oversamples the SCL and SDA lines with the system clock and finds START and STOP conditions. It compares the first byte after a START with its own 7-bit address. If enabled, it also compares that byte with the general call address. It shifts in the data bytes that follow. Each byte is acknowledged or refused depending on an assert-acknowledge control bit.

After every bus event the host must act on, the block raises an interrupt flag and loads an 8-bit status code. It then stretches the clock by holding SCL low until the host clears the flag. Clearing the assert-acknowledge bit has two effects. The block refuses the next data byte, and it stops answering its own address. It keeps watching the bus, so the host can cut the slave off and bring it back at any time.

The pads are open-drain and sit outside the block. The block only says when each line must be pulled low. A test input stands in for a lost master arbitration, so that the two entry codes for that case can be produced.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, the control register (offset 0) reads 0x00, the status register (offset 1) reads 0xF8, the interrupt output is low and neither SCL nor SDA is pulled low.
- R2: The block acknowledges an address byte whose upper seven bits equal bits 7..1 of the own-address register (offset 3) and whose direction bit (bit 0) is 0. For that it needs enable (control bit 6) and assert-acknowledge (control bit 2) both set. It pulls SDA low during the ninth clock, raises the flag (control bit 3, also the interrupt output) and reports status 0x60.
- R3: Address byte 0x00 is the general call. It is acknowledged with status 0x70 only when bit 0 of the own-address register is 1. Otherwise it is ignored: no ACK and no flag. An own address of 0 never matches as an own address.
- R4: An address byte with a mismatched address, or with the direction bit set to 1, gets no ACK and sets no flag.
- R5: After an acknowledged own address, each data byte taken with assert-acknowledge set is ACKed and gives status 0x80. After a general call the status is 0x90. The received byte reads back at offset 2.
- R6: If assert-acknowledge is 0 when the eighth data bit has been shifted in, the byte is refused (SDA left high). The status is 0x88 after an own address, or 0x98 after a general call. The slave then counts as not addressed, so later bytes get no ACK and no flag.
- R7: While assert-acknowledge is 0, the own address and the general call are not acknowledged. Setting the bit again restores recognition from the next START onward.
- R8: A STOP, or a repeated START, while the slave is addressed raises the flag with status 0xA0. A repeated START then begins a new address phase.
- R9: While the flag is set, the block holds SCL low. Writing a 1 to bit 3 at offset 1 clears the flag, releases SCL and returns the status register to 0xF8.
- R10: When the arbitration-lost test input is high as an address is acknowledged, the status is 0x68 for the own address and 0x78 for the general call, instead of 0x60 and 0x70.
- R11: A write to offset 0 sets the control bits written as 1 among bit 6 (enable), bit 5, bit 4 and bit 2 (assert-acknowledge); the flag bit 3 cannot be set by the host. A write to offset 1 clears the bits written as 1 among bits 6..2. While enable is 0 the slave acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low (acknowledge) |
| irq_o | output | 1 | Interrupt flag |
| arb_lost_sim_i | input | 1 | Test input: report the arbitration-lost entry codes |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 2 | Host register offset |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data for the selected offset |

## Verification
Suppose the bit counter or the state register goes astray. The ACK then lands on the wrong clock, or does not come at all. The master model samples SDA during the ninth clock, so it sees this on the very byte that went wrong. A wrong record of which address was matched, or of the acknowledge decision, shows up in the status code. That code is read a few system clocks after the ninth falling edge. A flag that fails to set, or sets when it should not, shows at once on the interrupt output and in the SCL hold. The master model would stall there, and its watchdog reports the stall.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  localparam int ADDR_BITS = 7;
  localparam int BYTE_BITS = 8;
  localparam int CNT_BITS  = $clog2(BYTE_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK
  } eng_state_t;

  localparam logic [7:0] CODE_OWN_W    = 8'h60;
  localparam logic [7:0] CODE_OWN_ARB  = 8'h68;
  localparam logic [7:0] CODE_GC       = 8'h70;
  localparam logic [7:0] CODE_GC_ARB   = 8'h78;
  localparam logic [7:0] CODE_OWN_ACK  = 8'h80;
  localparam logic [7:0] CODE_OWN_NACK = 8'h88;
  localparam logic [7:0] CODE_GC_ACK   = 8'h90;
  localparam logic [7:0] CODE_GC_NACK  = 8'h98;
  localparam logic [7:0] CODE_END      = 8'hA0;
  localparam logic [7:0] CODE_IDLE     = 8'hF8;

  localparam int CTL_EN   = 6;
  localparam int CTL_STA  = 5;
  localparam int CTL_STO  = 4;
  localparam int CTL_FLAG = 3;
  localparam int CTL_AA   = 2;

  localparam logic [7:0] SET_MASK = 8'b0111_0100;
  localparam logic [7:0] CLR_MASK = 8'b0111_1100;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam logic [1:0] OFS_OWN  = 2'd3;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] pipe_q;
  logic [DEPTH-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign lvl  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];
endmodule

// File: rtl/i2c_srx_engine.sv
module i2c_srx_engine
  import i2c_srx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_lvl,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 en,
  input  logic                 aa,
  input  logic                 gc_en,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 arb_lost,
  output logic                 sda_low,
  output logic                 ev_valid,
  output logic [7:0]           ev_code,
  output logic                 rx_load,
  output logic [BYTE_BITS-1:0] rx_byte
);
  eng_state_t           state_q, state_d;
  logic [CNT_BITS-1:0]  cnt_q, cnt_d;
  logic [BYTE_BITS-1:0] shift_q, shift_d;
  logic                 sda_low_q, sda_low_d;
  logic                 gc_q, gc_d;
  logic                 hit_own, hit_gc, addressed;

  assign hit_own   = (shift_q[BYTE_BITS-1:1] == own_addr) && (own_addr != '0);
  assign hit_gc    = gc_en && (shift_q[BYTE_BITS-1:1] == '0);
  assign addressed = (state_q == ST_AACK) || (state_q == ST_DATA) || (state_q == ST_DACK);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    shift_d   = shift_q;
    sda_low_d = sda_low_q;
    gc_d      = gc_q;
    ev_valid  = 1'b0;
    ev_code   = CODE_IDLE;
    rx_load   = 1'b0;
    if (!en) begin
      state_d   = ST_IDLE;
      sda_low_d = 1'b0;
      gc_d      = 1'b0;
    end else if (start_det || stop_det) begin
      if (addressed) begin
        ev_valid = 1'b1;
        ev_code  = CODE_END;
      end
      state_d   = start_det ? ST_ADDR : ST_IDLE;
      cnt_d     = '0;
      sda_low_d = 1'b0;
      gc_d      = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && (cnt_q < CNT_BITS'(BYTE_BITS))) begin
            shift_d = {shift_q[BYTE_BITS-2:0], sda_lvl};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CNT_BITS'(BYTE_BITS))) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (aa && !shift_q[0] && (hit_own || hit_gc)) begin
                state_d   = ST_AACK;
                sda_low_d = 1'b1;
                gc_d      = !hit_own;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              state_d   = ST_DACK;
              sda_low_d = aa;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            sda_low_d = 1'b0;
            state_d   = ST_DATA;
            ev_valid  = 1'b1;
            if (gc_q) ev_code = arb_lost ? CODE_GC_ARB : CODE_GC;
            else      ev_code = arb_lost ? CODE_OWN_ARB : CODE_OWN_W;
          end
        end
        ST_DACK: begin
          if (scl_fall) begin
            sda_low_d = 1'b0;
            ev_valid  = 1'b1;
            rx_load   = 1'b1;
            if (gc_q) ev_code = sda_low_q ? CODE_GC_ACK : CODE_GC_NACK;
            else      ev_code = sda_low_q ? CODE_OWN_ACK : CODE_OWN_NACK;
            state_d   = sda_low_q ? ST_DATA : ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      shift_q   <= '0;
      sda_low_q <= 1'b0;
      gc_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      shift_q   <= shift_d;
      sda_low_q <= sda_low_d;
      gc_q      <= gc_d;
    end
  end

  assign sda_low = sda_low_q;
  assign rx_byte = shift_q;

  // R2
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_q) |-> $past(scl_fall));

  // R4
  ack_only_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low_q |-> (state_q == ST_AACK || state_q == ST_DACK));

  // R8
  event_on_bus_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (scl_fall || start_det || stop_det));

  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == ST_IDLE && !sda_low_q));
endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
  import i2c_srx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [1:0]           addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic                 ev_valid_i,
  input  logic [7:0]           ev_code_i,
  input  logic                 rx_load_i,
  input  logic [BYTE_BITS-1:0] rx_byte_i,
  output logic                 en_o,
  output logic                 aa_o,
  output logic                 gc_en_o,
  output logic [ADDR_BITS-1:0] own_addr_o,
  output logic                 flag_o
);
  logic [7:0]           ctrl_q, ctrl_d;
  logic [7:0]           status_q, status_d;
  logic [7:0]           own_q;
  logic [BYTE_BITS-1:0] data_q;
  logic                 set_we, clr_we, own_we;

  assign set_we = wr_i && (addr_i == OFS_CTRL);
  assign clr_we = wr_i && (addr_i == OFS_STAT);
  assign own_we = wr_i && (addr_i == OFS_OWN);

  always_comb begin
    ctrl_d = ctrl_q;
    if (set_we) ctrl_d = ctrl_d | (wdata_i & SET_MASK);
    if (clr_we) ctrl_d = ctrl_d & ~(wdata_i & CLR_MASK);
    if (ev_valid_i) ctrl_d[CTL_FLAG] = 1'b1;
    if (ev_valid_i)            status_d = ev_code_i;
    else if (ctrl_d[CTL_FLAG]) status_d = status_q;
    else                       status_d = CODE_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= CODE_IDLE;
    end else begin
      ctrl_q   <= ctrl_d;
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= '0;
    else if (own_we) own_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (rx_load_i) data_q <= rx_byte_i;
  end

  always_comb begin
    case (addr_i)
      OFS_CTRL: rdata_o = ctrl_q;
      OFS_STAT: rdata_o = status_q;
      OFS_DATA: rdata_o = data_q;
      default:  rdata_o = own_q;
    endcase
  end

  assign en_o       = ctrl_q[CTL_EN];
  assign aa_o       = ctrl_q[CTL_AA];
  assign gc_en_o    = own_q[0];
  assign own_addr_o = own_q[7:1];
  assign flag_o     = ctrl_q[CTL_FLAG];

  // R9
  flag_clear_by_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[CTL_FLAG]) |-> $past(wr_i && addr_i == OFS_STAT && wdata_i[CTL_FLAG]));

  // R5
  event_loads_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_i |=> (ctrl_q[CTL_FLAG] && status_q == $past(ev_code_i)));

  // R1
  flag_has_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTL_FLAG] |-> (status_q != CODE_IDLE));
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_drive_low_o,
  output logic       sda_drive_low_o,
  output logic       irq_o,
  input  logic       arb_lost_sim_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o
);
  localparam int LINES    = 2;
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;

  logic [1:0]           rst_pipe_q;
  logic                 rst_n_int;
  logic [LINES-1:0]     line_lvl, line_prev;
  logic                 scl_rise, scl_fall, sda_rise, sda_fall;
  logic                 start_det, stop_det;
  logic                 en, aa, gc_en, flag, sda_low;
  logic [ADDR_BITS-1:0] own_addr;
  logic                 ev_valid, rx_load;
  logic [7:0]           ev_code;
  logic [BYTE_BITS-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  i2c_srx_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .din  ({sda_i, scl_i}),
    .lvl  (line_lvl),
    .prev (line_prev)
  );

  assign scl_rise  =  line_lvl[LINE_SCL] & ~line_prev[LINE_SCL];
  assign scl_fall  = ~line_lvl[LINE_SCL] &  line_prev[LINE_SCL];
  assign sda_rise  =  line_lvl[LINE_SDA] & ~line_prev[LINE_SDA];
  assign sda_fall  = ~line_lvl[LINE_SDA] &  line_prev[LINE_SDA];
  assign start_det = sda_fall & line_lvl[LINE_SCL] & line_prev[LINE_SCL];
  assign stop_det  = sda_rise & line_lvl[LINE_SCL] & line_prev[LINE_SCL];

  i2c_srx_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .sda_lvl  (line_lvl[LINE_SDA]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .en       (en),
    .aa       (aa),
    .gc_en    (gc_en),
    .own_addr (own_addr),
    .arb_lost (arb_lost_sim_i),
    .sda_low  (sda_low),
    .ev_valid (ev_valid),
    .ev_code  (ev_code),
    .rx_load  (rx_load),
    .rx_byte  (rx_byte)
  );

  i2c_srx_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .ev_valid_i(ev_valid),
    .ev_code_i (ev_code),
    .rx_load_i (rx_load),
    .rx_byte_i (rx_byte),
    .en_o      (en),
    .aa_o      (aa),
    .gc_en_o   (gc_en),
    .own_addr_o(own_addr),
    .flag_o    (flag)
  );

  assign scl_drive_low_o = flag;
  assign sda_drive_low_o = sda_low;
  assign irq_o           = flag;

  // R9
  no_ack_while_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(flag) |-> !sda_low);
endmodule

// File: tb/i2c_slave_rx_bench.sv
module i2c_slave_rx_bench;
  localparam int HALF = 12;
  localparam logic [6:0] OWN_A = 7'h3A;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_OWN = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic arb_sim = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic scl_dl, sda_dl, irq;
  logic scl_bus, sda_bus;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_dl;
  assign sda_bus = m_sda & ~sda_dl;

  i2c_slave_rx u_i2c_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_drive_low_o(scl_dl), .sda_drive_low_o(sda_dl), .irq_o(irq),
    .arb_lost_sim_i(arb_sim), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_scl();
    do @(negedge clk); while (scl_bus !== 1'b1);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_read(input logic [1:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic clear_flag();
    host_write(A_STAT, 8'h08);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; hw();
    m_sda = 1'b0; hw();
    m_scl = 1'b0; hw();
  endtask

  task automatic bus_rep_start();
    m_sda = 1'b1; hw();
    m_scl = 1'b1; wait_scl(); hw();
    m_sda = 1'b0; hw();
    m_scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw();
    m_scl = 1'b1; wait_scl(); hw();
    m_sda = 1'b1; hw();
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    m_sda = b; hw();
    m_scl = 1'b1; wait_scl(); hw();
    seen = sda_bus;
    m_scl = 1'b0; hw();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    acked = !s;
  endtask

  function automatic bit addr_hit(input logic [6:0] a, input bit rw, input bit gc, input bit aa, input bit en);
    return en && aa && !rw && ((a == OWN_A) || (a == 7'd0 && gc));
  endfunction

  function automatic int addr_code(input bit is_gc, input bit arb);
    if (is_gc) return arb ? 'h78 : 'h70;
    return arb ? 'h68 : 'h60;
  endfunction

  function automatic int data_code(input bit is_gc, input bit ack);
    if (is_gc) return ack ? 'h90 : 'h98;
    return ack ? 'h80 : 'h88;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    bit ack;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    host_read(A_CTRL, v); check("R1 ctrl", v, 'h00);
    host_read(A_STAT, v); check("R1 status", v, 'hF8);
    check("R1 irq", irq, 0);
    check("R1 scl release", scl_dl, 0);
    check("R1 sda release", sda_dl, 0);

    // R11 control set/clear, flag not host-settable
    host_write(A_OWN, {OWN_A, 1'b0});
    host_write(A_CTRL, 8'h44);
    host_read(A_CTRL, v); check("R11 set en+aa", v, 'h44);
    host_write(A_CTRL, 8'h08);
    host_read(A_CTRL, v); check("R11 flag not settable", v, 'h44);
    check("R11 irq stays low", irq, 0);
    host_write(A_CTRL, 8'h30);
    host_read(A_CTRL, v); check("R11 set bits 5,4", v, 'h74);
    host_write(A_STAT, 8'h30);
    host_read(A_CTRL, v); check("R11 clear bits 5,4", v, 'h44);

    // R2 own address, write
    bus_start();
    send_byte({OWN_A, 1'b0}, ack);
    check("R2 ack", ack, 1);
    check("R2 irq", irq, 1);
    host_read(A_STAT, v); check("R2 status", v, 'h60);
    repeat (30) @(negedge clk);
    check("R9 scl held", scl_dl, 1);
    clear_flag();
    check("R9 scl released", scl_dl, 0);
    host_read(A_STAT, v); check("R9 status idle", v, 'hF8);

    // R5 data byte
    send_byte(8'hA5, ack);
    check("R5 ack", ack, 1);
    host_read(A_STAT, v); check("R5 status", v, 'h80);
    host_read(A_DATA, v); check("R5 data", v, 'hA5);
    clear_flag();

    // R6 aa cleared mid-transfer
    host_write(A_STAT, 8'h04);
    send_byte(8'h5C, ack);
    check("R6 nack", ack, 0);
    host_read(A_STAT, v); check("R6 status", v, 'h88);
    host_read(A_DATA, v); check("R6 data", v, 'h5C);
    clear_flag();
    send_byte(8'h11, ack);
    check("R6 unaddressed no ack", ack, 0);
    check("R6 unaddressed no flag", irq, 0);
    bus_stop();
    check("R6 stop no event", irq, 0);

    // R7 aa clear ignores own address, then resumes
    bus_start();
    send_byte({OWN_A, 1'b0}, ack);
    check("R7 ignored ack", ack, 0);
    check("R7 ignored flag", irq, 0);
    bus_stop();
    host_write(A_CTRL, 8'h04);
    bus_start();
    send_byte({OWN_A, 1'b0}, ack);
    check("R7 resumed ack", ack, 1);
    host_read(A_STAT, v); check("R7 resumed status", v, 'h60);
    clear_flag();

    // R8 repeated start and stop while addressed
    bus_rep_start();
    check("R8 rep start flag", irq, 1);
    host_read(A_STAT, v); check("R8 rep start status", v, 'hA0);
    clear_flag();
    send_byte({OWN_A, 1'b0}, ack);
    check("R8 readdress ack", ack, 1);
    clear_flag();
    bus_stop();
    check("R8 stop flag", irq, 1);
    host_read(A_STAT, v); check("R8 stop status", v, 'hA0);
    clear_flag();

    // R3 general call disabled / enabled
    bus_start();
    send_byte(8'h00, ack);
    check("R3 gc off ack", ack, 0);
    check("R3 gc off flag", irq, 0);
    bus_stop();
    host_write(A_OWN, {OWN_A, 1'b1});
    bus_start();
    send_byte(8'h00, ack);
    check("R3 gc ack", ack, 1);
    host_read(A_STAT, v); check("R3 gc status", v, 'h70);
    clear_flag();
    send_byte(8'h3C, ack);
    host_read(A_STAT, v); check("R5 gc data status", v, 'h90);
    clear_flag();
    host_write(A_STAT, 8'h04);
    send_byte(8'h3D, ack);
    check("R6 gc nack", ack, 0);
    host_read(A_STAT, v); check("R6 gc status", v, 'h98);
    clear_flag();
    host_write(A_CTRL, 8'h04);
    bus_stop();

    // R4 mismatch and read direction
    bus_start();
    send_byte({7'h3B, 1'b0}, ack);
    check("R4 mismatch ack", ack, 0);
    bus_stop();
    bus_start();
    send_byte({OWN_A, 1'b1}, ack);
    check("R4 read dir ack", ack, 0);
    check("R4 read dir flag", irq, 0);
    bus_stop();

    // R10 arbitration-lost codes
    arb_sim = 1'b1;
    bus_start();
    send_byte({OWN_A, 1'b0}, ack);
    host_read(A_STAT, v); check("R10 own arb", v, 'h68);
    clear_flag();
    bus_rep_start();
    clear_flag();
    send_byte(8'h00, ack);
    host_read(A_STAT, v); check("R10 gc arb", v, 'h78);
    clear_flag();
    bus_stop();
    clear_flag();
    arb_sim = 1'b0;

    // R11 enable low
    host_write(A_STAT, 8'h40);
    bus_start();
    send_byte({OWN_A, 1'b0}, ack);
    check("R11 disabled ack", ack, 0);
    check("R11 disabled flag", irq, 0);
    bus_stop();
    host_write(A_CTRL, 8'h40);

    // random transactions
    void'($urandom(32'd1234));
    for (int t = 0; t < 30; t++) begin
      bit gc_on, aa_on, arb, rw, hit, live, is_gc, aa_now;
      logic [6:0] a7;
      logic [7:0] d;
      int sel, nb;
      gc_on = 1'($urandom % 2);
      aa_on = ($urandom % 4) != 0;
      arb   = 1'($urandom % 2);
      rw    = ($urandom % 5) == 0;
      sel   = $urandom % 4;
      a7 = (sel == 1) ? 7'd0 : (sel == 2) ? 7'($urandom % 128) : OWN_A;
      host_write(A_OWN, {OWN_A, gc_on});
      host_write(aa_on ? A_CTRL : A_STAT, 8'h04);
      arb_sim = arb;
      bus_start();
      send_byte({a7, rw}, ack);
      hit = addr_hit(a7, rw, gc_on, aa_on, 1'b1);
      is_gc = (a7 == 7'd0);
      check("R4 random addr ack", ack, hit);
      check("R2 random addr flag", irq, hit);
      if (hit) begin
        host_read(A_STAT, v); check("R10 random addr code", v, addr_code(is_gc, arb));
        clear_flag();
      end
      live = hit;
      nb = 1 + ($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        aa_now = ($urandom % 3) != 0;
        host_write(aa_now ? A_CTRL : A_STAT, 8'h04);
        d = 8'($urandom);
        send_byte(d, ack);
        if (live) begin
          check("R6 random data ack", ack, aa_now);
          host_read(A_STAT, v); check("R5 random data code", v, data_code(is_gc, aa_now));
          host_read(A_DATA, v); check("R5 random data byte", v, d);
          clear_flag();
          if (!aa_now) live = 1'b0;
        end else begin
          check("R6 random idle ack", ack, 0);
          check("R6 random idle flag", irq, 0);
        end
      end
      bus_stop();
      check("R8 random stop flag", irq, live);
      if (live) begin
        host_read(A_STAT, v); check("R8 random stop code", v, 'hA0);
        clear_flag();
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule